// File: doc/BRIEF.md
# Parallel Flash Bus-Operation Decoder

This block is the device-side front end of an asynchronous parallel NOR-style memory with a 16-bit data bus. A fast internal sampling clock observes the four active-low control pins: chip enable, output enable, write enable and the hardware reset pin. Each pin passes through a synchronizer and a glitch filter. The filtered levels are then decoded into one of five bus operations: reset, standby, output disable, read or write.

During a read, the block forwards the address to an array-read port. It drives the returned word on the data bus and asserts a tri-state enable. During a write, the address is captured when the second of chip enable and write enable goes low. The data is captured when the first of them goes high. The captured pair is then handed to a command interpreter as a one-clock strobe.

A write is dropped if output enable goes low or the reset pin asserts before it completes. Pulses on the control pins that are shorter than a parameterised number of sampling clocks leave no trace.

Top module: `flash_busop_decoder`

## Requirements
- R1: With chip enable, output enable and reset pin in their active/idle read levels (chip enable low, output enable low, write enable high, reset pin high), `dq_oe` is 1, `arr_rd_addr` equals `addr_i`, and `dq_o` presents `arr_rd_data` one clock after it is returned.
- R2: `bus_state` reports the decoded operation as 0 = reset, 1 = standby, 2 = output disable, 3 = read, 4 = write. Write is chip enable and write enable low with output enable high. Chip enable, output enable and write enable all low decodes as output disable.
- R3: With chip enable high and the reset pin high, `bus_state` is 1 and `dq_oe` is 0, whatever output enable and write enable are.
- R4: With chip enable low and both output enable and write enable high, `bus_state` is 2 and `dq_oe` is 0.
- R5: With the reset pin low, `bus_state` is 0 and `dq_oe` is 0 regardless of the other pins. A write under way when the reset pin falls produces no command.
- R6: The command address is the value of `addr_i` at the moment both chip enable and write enable have become low. Later address changes do not alter it.
- R7: The command data is the value of `dq_i` at the moment the first of chip enable or write enable returns high. Data changes before or after that moment do not alter it.
- R8: Each accepted write yields exactly one `cmd_valid` pulse, one clock long, carrying that write's address and data.
- R9: If output enable is low at any point while chip enable and write enable are both low, that write yields no `cmd_valid`.
- R10: A pulse on chip enable, write enable or the reset pin lasting fewer than FILT_CYCLES sampling clocks changes neither `bus_state` nor any output.
- R11: `dq_oe` falls no later than one sampling clock after `bus_state` leaves the read code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset of the sampling logic |
| chip_en_n | input | 1 | Chip enable pin, active low |
| out_en_n | input | 1 | Output enable pin, active low |
| wr_en_n | input | 1 | Write enable pin, active low |
| rst_pin_n | input | 1 | Hardware reset pin, active low |
| addr_i | input | ADDR_W | Word address pins |
| dq_i | input | DATA_W | Data bus, input side |
| arr_rd_data | input | DATA_W | Word returned by the array for `arr_rd_addr` |
| arr_rd_addr | output | ADDR_W | Address presented to the array-read port |
| dq_o | output | DATA_W | Data bus, output side |
| dq_oe | output | 1 | Data bus drive enable (0 = high impedance) |
| cmd_valid | output | 1 | One-clock strobe for an accepted write |
| cmd_addr | output | ADDR_W | Address latched for the write |
| cmd_data | output | DATA_W | Data latched for the write |
| bus_state | output | 3 | Decoded bus operation code |

## Verification
The bench builds the block with ADDR_W=10, SYNC_STAGES=2, FILT_CYCLES=3 and OE_FILT_CYCLES=1. With these values a two-clock pulse sits just under the glitch threshold, so rejection on each strobe is exercised in a few cycles. The short filter also keeps every write short enough to drive both strobe orderings and both abort cases, with the address and data moved inside the window. The ten-bit address lets the bench model the array as a computed function and check every read word against it.

// File: rtl/fbd_pkg.sv
package fbd_pkg;

   typedef enum logic [2:0] {
      BUS_RESET   = 3'd0,
      BUS_STANDBY = 3'd1,
      BUS_OUTDIS  = 3'd2,
      BUS_READ    = 3'd3,
      BUS_WRITE   = 3'd4
   } bus_op_e;

endpackage

// File: rtl/fbd_glitch_filter.sv
module fbd_glitch_filter #(
   parameter int   SYNC_STAGES = 2,
   parameter int   FILT_CYCLES = 3,
   parameter logic RESET_VAL   = 1'b1
) (
   input  logic clk,
   input  logic sys_rst_n,
   input  logic raw_i,
   output logic filt_o
);

   localparam int CW = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("fbd_glitch_filter: SYNC_STAGES must be at least 2");
      end
      if (FILT_CYCLES < 1) begin : g_bad_filt
         $error("fbd_glitch_filter: FILT_CYCLES must be at least 1");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   sync_out;
   logic                   filt_q;

   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) chain_q <= {SYNC_STAGES{RESET_VAL}};
      else            chain_q <= {chain_q[SYNC_STAGES-2:0], raw_i};
   end

   assign sync_out = chain_q[SYNC_STAGES-1];

   generate
      if (FILT_CYCLES == 1) begin : g_direct
         always_ff @(posedge clk or negedge sys_rst_n) begin
            if (!sys_rst_n) filt_q <= RESET_VAL;
            else            filt_q <= sync_out;
         end
      end else begin : g_count
         logic [CW-1:0] run_q;
         always_ff @(posedge clk or negedge sys_rst_n) begin
            if (!sys_rst_n) begin
               filt_q <= RESET_VAL;
               run_q  <= '0;
            end else if (sync_out == filt_q) begin
               run_q <= '0;
            end else if (run_q == CW'(FILT_CYCLES - 1)) begin
               filt_q <= sync_out;
               run_q  <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
      end
   endgenerate

   assign filt_o = filt_q;

   // R10: the filtered level only moves toward a synchronized level that differs from it
   a_r10_filter_moves_to_sync: assert property (@(posedge clk) disable iff (!sys_rst_n)
      !$stable(filt_q) |-> ($past(sync_out) != $past(filt_q)));

endmodule

// File: rtl/fbd_classify.sv
module fbd_classify
   import fbd_pkg::*;
(
   input  logic    ce_f,
   input  logic    oe_f,
   input  logic    we_f,
   input  logic    rst_f,
   output bus_op_e op_o
);

   always_comb begin
      if (!rst_f)                op_o = BUS_RESET;
      else if (ce_f)             op_o = BUS_STANDBY;
      else if (!oe_f && we_f)    op_o = BUS_READ;
      else if (oe_f && !we_f)    op_o = BUS_WRITE;
      else                       op_o = BUS_OUTDIS;
   end

endmodule

// File: rtl/fbd_write_capture.sv
module fbd_write_capture #(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              sys_rst_n,
   input  logic              ce_f,
   input  logic              oe_f,
   input  logic              we_f,
   input  logic              rst_f,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              cmd_valid,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_data
);

   logic              both_low;
   logic              both_q;
   logic              start_w;
   logic              stop_w;
   logic              armed_q;
   logic [ADDR_W-1:0] addr_q;

   assign both_low = !ce_f && !we_f;
   assign start_w  = both_low && !both_q;
   assign stop_w   = !both_low && both_q;

   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         both_q    <= 1'b0;
         armed_q   <= 1'b0;
         addr_q    <= '0;
         cmd_valid <= 1'b0;
         cmd_addr  <= '0;
         cmd_data  <= '0;
      end else begin
         both_q    <= both_low;
         cmd_valid <= 1'b0;
         if (start_w) begin
            armed_q <= oe_f && rst_f;
            addr_q  <= addr_i;
         end else if (armed_q && (!oe_f || !rst_f)) begin
            armed_q <= 1'b0;
         end else if (stop_w) begin
            armed_q <= 1'b0;
            if (armed_q) begin
               cmd_valid <= 1'b1;
               cmd_addr  <= addr_q;
               cmd_data  <= data_i;
            end
         end
      end
   end

   // R8: a command strobe never lasts two clocks
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!sys_rst_n)
      cmd_valid |=> !cmd_valid);

   // R9: a command only follows a window that ended with output enable high and reset idle
   a_r9_no_cmd_after_abort: assert property (@(posedge clk) disable iff (!sys_rst_n)
      cmd_valid |-> ($past(oe_f) && $past(rst_f) && $past(both_q)));

endmodule

// File: rtl/fbd_read_drive.sv
module fbd_read_drive
   import fbd_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              sys_rst_n,
   input  bus_op_e           op_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe
);

   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         dq_o  <= '0;
         dq_oe <= 1'b0;
      end else begin
         dq_oe <= (op_i == BUS_READ);
         if (op_i == BUS_READ) dq_o <= rd_data_i;
      end
   end

   // R1: a read decode turns the drive on at the next clock
   a_r1_drive_on_read: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (op_i == BUS_READ) |=> dq_oe);

   // R11: leaving the read decode releases the bus at the next clock
   a_r11_release_after_read: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (op_i != BUS_READ) |=> !dq_oe);

endmodule

// File: rtl/flash_busop_decoder.sv
module flash_busop_decoder
   import fbd_pkg::*;
#(
   parameter int ADDR_W         = 24,
   parameter int DATA_W         = 16,
   parameter int SYNC_STAGES    = 2,
   parameter int FILT_CYCLES    = 3,
   parameter int OE_FILT_CYCLES = 1
) (
   input  logic              clk,
   input  logic              sys_rst_n,
   input  logic              chip_en_n,
   input  logic              out_en_n,
   input  logic              wr_en_n,
   input  logic              rst_pin_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] dq_i,
   input  logic [DATA_W-1:0] arr_rd_data,
   output logic [ADDR_W-1:0] arr_rd_addr,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe,
   output logic              cmd_valid,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_data,
   output logic [2:0]        bus_state
);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("flash_busop_decoder: ADDR_W and DATA_W must be positive");
      end
   endgenerate

   localparam int NPIN = 4;
   localparam logic [NPIN-1:0] PIN_RESET_VAL = 4'b0111;

   logic [NPIN-1:0] raw_pins;
   logic [NPIN-1:0] filt_pins;
   bus_op_e         op;

   // pin order: [3]=reset pin, [2]=write enable, [1]=output enable, [0]=chip enable
   assign raw_pins = {rst_pin_n, wr_en_n, out_en_n, chip_en_n};

   generate
      for (genvar i = 0; i < NPIN; i++) begin : g_pin
         localparam int N_FILT = (i == 1) ? OE_FILT_CYCLES : FILT_CYCLES;
         fbd_glitch_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_CYCLES (N_FILT),
            .RESET_VAL   (PIN_RESET_VAL[i])
         ) u_filt (
            .clk       (clk),
            .sys_rst_n (sys_rst_n),
            .raw_i     (raw_pins[i]),
            .filt_o    (filt_pins[i])
         );
      end
   endgenerate

   fbd_classify u_classify (
      .ce_f  (filt_pins[0]),
      .oe_f  (filt_pins[1]),
      .we_f  (filt_pins[2]),
      .rst_f (filt_pins[3]),
      .op_o  (op)
   );

   fbd_read_drive #(.DATA_W(DATA_W)) u_read (
      .clk       (clk),
      .sys_rst_n (sys_rst_n),
      .op_i      (op),
      .rd_data_i (arr_rd_data),
      .dq_o      (dq_o),
      .dq_oe     (dq_oe)
   );

   fbd_write_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_write (
      .clk       (clk),
      .sys_rst_n (sys_rst_n),
      .ce_f      (filt_pins[0]),
      .oe_f      (filt_pins[1]),
      .we_f      (filt_pins[2]),
      .rst_f     (filt_pins[3]),
      .addr_i    (addr_i),
      .data_i    (dq_i),
      .cmd_valid (cmd_valid),
      .cmd_addr  (cmd_addr),
      .cmd_data  (cmd_data)
   );

   assign arr_rd_addr = addr_i;
   assign bus_state   = op;

   // R5: reset decode never coexists with a driven bus or a command
   a_r5_reset_quiet: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (op == BUS_RESET) |=> (!dq_oe && !cmd_valid));

   // R3: standby releases the bus at the next clock
   a_r3_standby_hiz: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (op == BUS_STANDBY) |=> !dq_oe);

endmodule

// File: tb/flash_busop_decoder_bench.sv
module flash_busop_decoder_bench;

   localparam int AW = 10;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          sys_rst_n;
   logic          chip_en_n, out_en_n, wr_en_n, rst_pin_n;
   logic [AW-1:0] addr_i;
   logic [DW-1:0] dq_i;
   logic [DW-1:0] arr_rd_data;
   logic [AW-1:0] arr_rd_addr;
   logic [DW-1:0] dq_o;
   logic          dq_oe;
   logic          cmd_valid;
   logic [AW-1:0] cmd_addr;
   logic [DW-1:0] cmd_data;
   logic [2:0]    bus_state;

   int checks = 0;
   int errors = 0;
   logic [AW+DW-1:0] sbq [$];
   logic             prev_valid = 1'b0;

   always #4 clk = ~clk;

   function automatic logic [DW-1:0] arr_word(input logic [AW-1:0] a);
      return {a[5:0], a} ^ 16'h5A3C;
   endfunction

   assign arr_rd_data = arr_word(arr_rd_addr);

   flash_busop_decoder #(
      .ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2), .FILT_CYCLES(3), .OE_FILT_CYCLES(1)
   ) u_flash_busop_decoder (
      .clk(clk), .sys_rst_n(sys_rst_n),
      .chip_en_n(chip_en_n), .out_en_n(out_en_n), .wr_en_n(wr_en_n), .rst_pin_n(rst_pin_n),
      .addr_i(addr_i), .dq_i(dq_i), .arr_rd_data(arr_rd_data), .arr_rd_addr(arr_rd_addr),
      .dq_o(dq_o), .dq_oe(dq_oe), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
      .cmd_data(cmd_data), .bus_state(bus_state)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // scoreboard monitor: pops one expected write per strobe
   always @(negedge clk) begin
      if (sys_rst_n) begin
         if (cmd_valid && prev_valid) chk("R8 strobe length", 32'd2, 32'd1);
         if (cmd_valid) begin
            if (sbq.size() == 0) begin
               chk("R9 unexpected command", {6'd0, cmd_addr, cmd_data}, 32'd0);
            end else begin
               logic [AW+DW-1:0] e;
               e = sbq.pop_front();
               chk("R6 command address", 32'(cmd_addr), 32'(e[AW+DW-1:DW]));
               chk("R7 command data", 32'(cmd_data), 32'(e[DW-1:0]));
            end
         end
         prev_valid = cmd_valid;
      end
   end

   // driver: one write, choosing which strobe falls first and which rises first
   task automatic do_write(input bit ce_leads_fall, input bit ce_leads_rise,
                           input logic [AW-1:0] a, input logic [DW-1:0] d);
      addr_i = ~a; dq_i = ~d;
      if (ce_leads_fall) chip_en_n = 1'b0; else wr_en_n = 1'b0;
      cyc(6);
      addr_i = a;
      cyc(1);
      if (ce_leads_fall) wr_en_n = 1'b0; else chip_en_n = 1'b0;
      cyc(10);
      @(negedge clk);
      chk("R2 write code", 32'(bus_state), 32'd4);
      chk("R2 write keeps bus released", 32'(dq_oe), 32'd0);
      addr_i = a ^ 10'h155; dq_i = d;   // R6: later address move must not count
      cyc(4);
      sbq.push_back({a, d});
      if (ce_leads_rise) chip_en_n = 1'b1; else wr_en_n = 1'b1;
      cyc(10);
      dq_i = ~d; addr_i = ~a;           // R7: data after the first rise must not count
      cyc(2);
      chip_en_n = 1'b1; wr_en_n = 1'b1;
      cyc(10);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      int t_state, t_oe;
      bit bad;
      sys_rst_n = 1'b0;
      chip_en_n = 1'b1; out_en_n = 1'b1; wr_en_n = 1'b1; rst_pin_n = 1'b1;
      addr_i = '0; dq_i = '0;
      cyc(3);
      @(negedge clk);
      chk("R5 reset code during system reset", 32'(bus_state), 32'd0);
      chk("R5 bus released during system reset", 32'(dq_oe), 32'd0);
      chk("R8 no strobe during system reset", 32'(cmd_valid), 32'd0);
      sys_rst_n = 1'b1;
      cyc(10);
      @(negedge clk);
      chk("R3 standby after reset", 32'(bus_state), 32'd1);

      // R1: reads
      addr_i = 10'h123; chip_en_n = 1'b0; out_en_n = 1'b0;
      cyc(10);
      @(negedge clk);
      chk("R1 read code", 32'(bus_state), 32'd3);
      chk("R1 drive enabled", 32'(dq_oe), 32'd1);
      chk("R1 read word", 32'(dq_o), 32'(arr_word(10'h123)));
      chk("R1 array address", 32'(arr_rd_addr), 32'h123);
      addr_i = 10'h2A0;
      cyc(3);
      @(negedge clk);
      chk("R1 read word after address move", 32'(dq_o), 32'(arr_word(10'h2A0)));

      // R10: reset-pin glitch during a read
      rst_pin_n = 1'b0; cyc(2); rst_pin_n = 1'b1;
      bad = 1'b0;
      for (int i = 0; i < 15; i++) begin
         @(negedge clk);
         if (!dq_oe || bus_state != 3'd3) bad = 1'b1;
      end
      chk("R10 reset-pin glitch ignored", 32'(bad), 32'd0);

      // R11: release timing when the read ends
      out_en_n = 1'b1;
      t_state = -1; t_oe = -1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (t_state < 0 && bus_state != 3'd3) t_state = i;
         if (t_oe < 0 && !dq_oe) t_oe = i;
      end
      chk("R11 release within one clock", 32'((t_state >= 0) && (t_oe >= t_state) && (t_oe - t_state <= 1)), 32'd1);

      // R4: output disable
      chk("R4 output disable code", 32'(bus_state), 32'd2);
      chk("R4 output disable released", 32'(dq_oe), 32'd0);

      // R3: standby with other strobes active
      chip_en_n = 1'b1; out_en_n = 1'b0; wr_en_n = 1'b0;
      cyc(10);
      @(negedge clk);
      chk("R3 standby code", 32'(bus_state), 32'd1);
      chk("R3 standby released", 32'(dq_oe), 32'd0);

      // R10: chip-enable glitch from standby with output enable low
      chip_en_n = 1'b0; cyc(2); chip_en_n = 1'b1;
      bad = 1'b0;
      for (int i = 0; i < 15; i++) begin
         @(negedge clk);
         if (dq_oe || bus_state != 3'd1) bad = 1'b1;
      end
      chk("R10 chip-enable glitch ignored", 32'(bad), 32'd0);
      out_en_n = 1'b1; wr_en_n = 1'b1;
      cyc(10);

      // R6 R7 R8: writes in all strobe orderings
      do_write(1'b1, 1'b1, 10'h0A5, 16'hBEEF);
      do_write(1'b0, 1'b0, 10'h31C, 16'h1234);
      do_write(1'b1, 1'b0, 10'h3FF, 16'hFFFF);
      do_write(1'b0, 1'b1, 10'h000, 16'h0000);

      // R9: output enable low during a write
      addr_i = 10'h111; dq_i = 16'h7777;
      chip_en_n = 1'b0; wr_en_n = 1'b0; cyc(10);
      out_en_n = 1'b0; cyc(10);
      @(negedge clk);
      chk("R2 all strobes low decodes as output disable", 32'(bus_state), 32'd2);
      out_en_n = 1'b1; cyc(10);
      chip_en_n = 1'b1; wr_en_n = 1'b1; cyc(15);

      // R5: reset pin during a write
      addr_i = 10'h222; dq_i = 16'h8888;
      chip_en_n = 1'b0; wr_en_n = 1'b0; cyc(10);
      rst_pin_n = 1'b0; cyc(10);
      @(negedge clk);
      chk("R5 reset code", 32'(bus_state), 32'd0);
      out_en_n = 1'b0; cyc(10);
      @(negedge clk);
      chk("R5 reset overrides read levels", 32'(dq_oe), 32'd0);
      out_en_n = 1'b1; rst_pin_n = 1'b1; cyc(10);
      chip_en_n = 1'b1; wr_en_n = 1'b1; cyc(15);

      // R10: write-enable glitch with chip enable low
      chip_en_n = 1'b0; cyc(8);
      wr_en_n = 1'b0; cyc(2); wr_en_n = 1'b1;
      bad = 1'b0;
      for (int i = 0; i < 15; i++) begin
         @(negedge clk);
         if (bus_state != 3'd2) bad = 1'b1;
      end
      chk("R10 write-enable glitch ignored", 32'(bad), 32'd0);
      chip_en_n = 1'b1; cyc(20);

      chk("R8 every expected write delivered", 32'(sbq.size()), 32'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule